// File: doc/BRIEF.md
# Enhanced Register Write Lock

This block is the register-file guard for one serial channel. It holds four control registers and one feature register. A host writes them through a simple synchronous write port and reads them through a combinational read port. Each control register has a legacy part and an enhanced part. Bit 4 of the feature register, called the open bit, decides whether the enhanced parts may be changed.

With the open bit at 1, every write lands in full. Once software clears the open bit, the enhanced parts are frozen at the values they held, and they stay in force on the value outputs. Older driver code that rewrites whole registers therefore cannot disturb the enhanced settings. The legacy parts stay writable at all times. After reset every register is zero, so the open bit is clear and all enhanced fields are in their legacy-compatible state.

The held register values are driven out continuously to the channel logic. The serial datapath, the FIFOs and the bus bridge sit outside this block.

Top module: `enh_reg_lock`

## Requirements
- R1: After reset, all five registers read zero. The open bit is feature bit 4, so it is 0 and the enhanced fields are locked.
- R2: The write and read address maps are the same: 0 interrupt-enable, 1 interrupt-status, 2 FIFO-control, 3 modem-control, 4 feature. Addresses 5 to 7 read as 0.
- R3: The protected masks are 0xF0 for interrupt-enable (bits 7:4), 0x30 for interrupt-status (bits 5:4), 0x30 for FIFO-control (bits 5:4) and 0xE0 for modem-control (bits 7:5).
- R4: While the open bit is 1, a write to a control register stores all eight data bits.
- R5: While the open bit is 0, a write to a control register leaves the protected bits unchanged.
- R6: The unprotected bits of a control register take the written data on every write to that register, whatever the state of the open bit.
- R7: A write to a control register is judged against the open bit held before that write. A change to the open bit applies from the next write cycle, including a write in the cycle directly after it.
- R8: The feature register stores all eight written bits on every write to address 4, whatever the state of the open bit.
- R9: rd_data shows the held value of the register at rd_addr in the same cycle, with no clock edge in between.
- R10: The value outputs show the held registers continuously. Locked values stay visible, and a register keeps its value in every cycle in which it is not written.
- R11: A write to address 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Held value at rd_addr (combinational) |
| ien_q | output | 8 | Held interrupt-enable register |
| ist_q | output | 8 | Held interrupt-status register |
| fctl_q | output | 8 | Held FIFO-control register |
| mctl_q | output | 8 | Held modem-control register |
| feat_q | output | 8 | Held feature register |
| enh_open | output | 1 | Current open bit (feature bit 4) |

## Verification
A write presented before a rising edge is due on the value outputs one cycle later, and so is any change to the open bit. rd_data follows rd_addr within the same cycle. The bench drives every input on the falling edge and samples at the next falling edge, after exactly one rising edge. At that point both the new register contents and the read path for the newly driven address are settled. A model in the bench decides whether each write is locked from the open bit as it stood before that write, which is how back-to-back lock and unlock sequences are checked.

// File: rtl/enh_lock_pkg.sv
package enh_lock_pkg;

  localparam int ELK_DW      = 8;
  localparam int ELK_AW      = 3;
  localparam int ELK_NCTL    = 4;
  localparam int ELK_NREG    = ELK_NCTL + 1;
  localparam int ELK_OPENBIT = 4;

  typedef enum logic [ELK_AW-1:0] {
    ADDR_IEN  = 3'd0,
    ADDR_IST  = 3'd1,
    ADDR_FCTL = 3'd2,
    ADDR_MCTL = 3'd3,
    ADDR_FEAT = 3'd4
  } elk_addr_e;

  // protected-field mask for each control register index
  function automatic logic [ELK_DW-1:0] prot_mask(input int idx);
    logic [ELK_DW-1:0] m;
    case (idx)
      0:       m = 8'hF0;
      1:       m = 8'h30;
      2:       m = 8'h30;
      3:       m = 8'hE0;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/enh_lock_rst_sync.sv
module enh_lock_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/enh_lock_wr_dec.sv
module enh_lock_wr_dec #(
  parameter int AW   = 3,
  parameter int NREG = 5
) (
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  output logic [NREG-1:0] we_o
);

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign we_o[k] = wr_en_i && (wr_addr_i == AW'(k));
  end

endmodule

// File: rtl/enh_lock_field_reg.sv
module enh_lock_field_reg #(
  parameter int            DW   = 8,
  parameter logic [DW-1:0] MASK = '0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          unlock_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_r;
  logic [DW-1:0] q_d;
  logic [DW-1:0] prot_src;

  // protected bits come from the write data only while unlocked
  always_comb begin
    prot_src = unlock_i ? wdata_i : q_r;
    q_d      = (wdata_i & ~MASK) | (prot_src & MASK);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= '0;
    end else if (we_i) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/enh_lock_rd_mux.sv
module enh_lock_rd_mux #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NREG = 5
) (
  input  logic [AW-1:0]            rd_addr_i,
  input  logic [NREG-1:0][DW-1:0]  regs_i,
  output logic [DW-1:0]            rd_data_o
);

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr_i == AW'(k)) begin
        rd_data_o = regs_i[k];
      end
    end
  end

endmodule

// File: rtl/enh_reg_lock.sv
module enh_reg_lock
  import enh_lock_pkg::*;
#(
  parameter int DW      = ELK_DW,
  parameter int AW      = ELK_AW,
  parameter int OPENBIT = ELK_OPENBIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ien_q,
  output logic [DW-1:0] ist_q,
  output logic [DW-1:0] fctl_q,
  output logic [DW-1:0] mctl_q,
  output logic [DW-1:0] feat_q,
  output logic          enh_open
);

  localparam int NCTL = ELK_NCTL;
  localparam int NREG = NCTL + 1;
  localparam int FIDX = NCTL;

  logic                    rst_sync_n;
  logic [NREG-1:0]         we;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic                    open_q;

  enh_lock_rst_sync u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  enh_lock_wr_dec #(.AW(AW), .NREG(NREG)) u_dec (
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .we_o      (we)
  );

  assign open_q = regs_q[FIDX][OPENBIT];

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    enh_lock_field_reg #(
      .DW   (DW),
      .MASK (DW'(prot_mask(k)))
    ) u_reg (
      .clk      (clk),
      .rst_ni   (rst_sync_n),
      .we_i     (we[k]),
      .unlock_i (open_q),
      .wdata_i  (wr_data),
      .q_o      (regs_q[k])
    );
  end

  // feature register: no protected bits
  enh_lock_field_reg #(.DW(DW), .MASK('0)) u_feat (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .we_i     (we[FIDX]),
    .unlock_i (1'b0),
    .wdata_i  (wr_data),
    .q_o      (regs_q[FIDX])
  );

  enh_lock_rd_mux #(.DW(DW), .AW(AW), .NREG(NREG)) u_rd (
    .rd_addr_i (rd_addr),
    .regs_i    (regs_q),
    .rd_data_o (rd_data)
  );

  assign ien_q    = regs_q[0];
  assign ist_q    = regs_q[1];
  assign fctl_q   = regs_q[2];
  assign mctl_q   = regs_q[3];
  assign feat_q   = regs_q[FIDX];
  assign enh_open = open_q;

endmodule

// File: rtl/enh_reg_lock_chk.sv
module enh_reg_lock_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] ien_q,
  input logic [7:0] ist_q,
  input logic [7:0] fctl_q,
  input logic [7:0] mctl_q,
  input logic [7:0] feat_q
);

  logic [3:0][7:0] ctl;
  logic [4:0][7:0] all_regs;

  assign ctl      = {mctl_q, fctl_q, ist_q, ien_q};
  assign all_regs = {feat_q, ctl};

  function automatic logic [7:0] m_of(input int k);
    case (k)
      0:       return 8'hF0;
      3:       return 8'hE0;
      default: return 8'h30;
    endcase
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_reg
    localparam logic [7:0] M = m_of(k);

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && wr_addr == 3'(k) && !feat_q[4]) |=> ((ctl[k] & M) == $past(ctl[k] & M)));

    // R4
    open_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && wr_addr == 3'(k) && feat_q[4]) |=> ((ctl[k] & M) == ($past(wr_data) & M)));

    // R6
    legacy_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && wr_addr == 3'(k)) |=> ((ctl[k] & ~M) == ($past(wr_data) & ~M)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !(wr_en && wr_addr == 3'(k)) |=> $stable(ctl[k]));
  end

  // R8
  feat_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == 3'd4) |=> (feat_q == $past(wr_data)));

  // R11
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr > 3'd4) |=> $stable(all_regs));

  // R9
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr <= 3'd4) |-> (rd_data == all_regs[rd_addr]));

  // R2
  read_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr > 3'd4) |-> (rd_data == 8'h00));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (all_regs == '0));

endmodule

bind enh_reg_lock enh_reg_lock_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .ien_q      (ien_q),
  .ist_q      (ist_q),
  .fctl_q     (fctl_q),
  .mctl_q     (mctl_q),
  .feat_q     (feat_q)
);

// File: tb/enh_reg_lock_tb.sv
module enh_reg_lock_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] ien_q, ist_q, fctl_q, mctl_q, feat_q;
  logic       enh_open;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [5];

  enh_reg_lock u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ien_q(ien_q), .ist_q(ist_q), .fctl_q(fctl_q), .mctl_q(mctl_q),
    .feat_q(feat_q), .enh_open(enh_open)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R3 masks
  function automatic logic [7:0] pmask(input int a);
    case (a)
      0: return 8'hF0;
      1: return 8'h30;
      2: return 8'h30;
      3: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] nextv(input int a, input logic [7:0] old,
                                       input logic [7:0] wd, input logic open);
    logic [7:0] m;
    m = pmask(a);
    return (wd & ~m) | ((open ? wd : old) & m);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_exp(input logic [2:0] a);
    return (a <= 3'd4) ? mdl[a] : 8'h00;
  endfunction

  // drive at falling edge, compare at next falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic [2:0] ra, input string tag);
    logic open;
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
    open = mdl[4][4];
    if (we && a <= 3'd4) mdl[a] = nextv(int'(a), mdl[a], d, open);
    @(negedge clk);
    chk({tag, " R10 ien"},  ien_q,  mdl[0]);
    chk({tag, " R10 ist"},  ist_q,  mdl[1]);
    chk({tag, " R10 fctl"}, fctl_q, mdl[2]);
    chk({tag, " R10 mctl"}, mctl_q, mdl[3]);
    chk({tag, " R8 feat"},  feat_q, mdl[4]);
    chk({tag, " R9 rd"},    rd_data, rd_exp(ra));
    chk({tag, " R7 open"},  {7'd0, enh_open}, {7'd0, mdl[4][4]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ien", ien_q, 8'h00);
    chk("R1 mctl", mctl_q, 8'h00);
    chk("R1 feat", feat_q, 8'h00);
    chk("R1 open", {7'd0, enh_open}, 8'h00);

    // R5 R6: locked after reset, only legacy bits land
    step(1'b1, 3'd0, 8'hFF, 3'd0, "R5 R6 locked ien");
    chk("R5 ien value", ien_q, 8'h0F);
    step(1'b1, 3'd3, 8'hFF, 3'd3, "R5 locked mctl");
    chk("R5 R3 mctl value", mctl_q, 8'h1F);
    // R8 open the lock
    step(1'b1, 3'd4, 8'h10, 3'd4, "R8 open");
    // R4 full writes
    step(1'b1, 3'd0, 8'hA5, 3'd0, "R4 ien");
    chk("R4 ien value", ien_q, 8'hA5);
    step(1'b1, 3'd1, 8'hFF, 3'd1, "R4 ist");
    step(1'b1, 3'd2, 8'h3C, 3'd2, "R4 fctl");
    // R7 lock then write in the next cycle
    step(1'b1, 3'd4, 8'hEF, 3'd4, "R7 close");
    step(1'b1, 3'd0, 8'h5A, 3'd0, "R7 blocked");
    chk("R7 ien value", ien_q, 8'hAA);
    // R11 R2 unmapped
    step(1'b1, 3'd6, 8'hFF, 3'd6, "R11 R2 unmapped");
    step(1'b1, 3'd7, 8'h00, 3'd5, "R11 R2 unmapped");
    // R7 reopen then write in the next cycle
    step(1'b1, 3'd4, 8'h10, 3'd0, "R7 reopen");
    step(1'b1, 3'd3, 8'hE0, 3'd3, "R7 open write");
    chk("R7 mctl value", mctl_q, 8'hE0);
    step(1'b0, 3'd3, 8'h00, 3'd7, "R10 idle");

    // random mix, R4 R5 R6 R9 R10
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic we;
      we = ($urandom % 4) != 0;
      a  = 3'($urandom % 8);
      if (($urandom % 4) == 0) a = 3'd4;
      d  = 8'($urandom);
      step(we, a, d, 3'($urandom % 8), "rnd");
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule